// File: doc/BRIEF.md
# Four-Bit Datapath ALU with Condition Codes

This block is the arithmetic and logic stage of a small processor datapath. It takes two 4-bit register operands and a 4-bit operation select, and returns a 4-bit result and a 4-bit condition-code vector. The whole path is combinational, so the outputs follow the inputs with no clock edge. Any flag register, instruction sequencing or wider data path lives outside the block.

The operations are addition, subtraction, bitwise AND, bitwise OR, one's complement of the first operand, and pass-through of the first operand. The sign and zero flags follow the result for every operation. The overflow and carry flags carry meaning only for addition and subtraction and read as zero for every other operation. On subtraction the carry flag means a borrow occurred. Select codes that no operation uses give a defined all-zero result, so the block has an output for every input.

Top module: `alu4_core`

## Requirements
- R1: With select 0000, the result is (A + B) mod 16.
- R2: With select 0001, the result is (A − B) mod 16.
- R3: With select 0010, the result is A AND B bit by bit. With select 0011, it is A OR B bit by bit.
- R4: With select 0100, the result is the bitwise inverse of A. With select 0101, the result is A unchanged.
- R5: The flag vector is laid out as bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C. N equals bit 3 of the result. Z is 1 exactly when the result is 0000.
- R6: For selects 0010 through 0101, V and C are both 0.
- R7: On addition, C is the unsigned carry out of bit 3, which is bit 4 of the 5-bit sum of the zero-extended operands.
- R8: On subtraction, C is the borrow. It is 1 exactly when A < B as unsigned numbers.
- R9: On addition, V is 1 exactly when A and B have equal sign bits and the result's sign bit differs from them.
- R10: On subtraction, V is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R11: For selects 0110 through 1111, the result is 0000 and the flags are 0100 (N=0, Z=1, V=0, C=0).
- R12: The outputs change together with the inputs inside one clock period. No clock edge is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rega | input | 4 | First operand A |
| regb | input | 4 | Second operand B |
| controls | input | 4 | Operation select |
| alu_out | output | 4 | Result |
| ccr_out | output | 4 | Condition codes {N, Z, V, C} |

## Verification
The bench aims at the edges of the signed range. 7+1 and 8−1 must raise V. A design that tested only the result sign, or took the sign from the wrong operand on subtraction, would miss these cases or flag false ones. The cases 0−1 and 7−F separate borrow from carry: a design that passed out the raw adder carry would show C inverted on every subtraction. Logic operations with large operands check that V and C stay at zero, and select codes above 0101 check for a defined zero result rather than a stale or latched value. Finally, the bench sweeps every operand pair under every select code against an integer model.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int OP_W = 4;
  localparam int CC_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOT  = 4'd4,
    OP_PASS = 4'd5
  } alu_op_e;

  // Condition codes, most significant first.
  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic cry;
  } cc_t;
endpackage

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy_bw,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   c;

  // Subtraction is A + ~B + 1: invert B and feed sub into the carry-in.
  assign b_eff = b ^ {W{sub}};
  assign c[0]  = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
    assign c[i+1]   = (a[i] & b_eff[i]) | (c[i] & (a[i] ^ b_eff[i]));
  end

  // A borrow is the absence of carry out during subtraction.
  assign cy_bw = c[W] ^ sub;
  // Signed overflow happens when the carries into and out of the sign bit disagree.
  assign ovf   = c[W] ^ c[W-1];
endmodule

// File: rtl/alu4_logic.sv
module alu4_logic
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_NOT:  res = ~a;
      OP_PASS: res = a;
      default: res = '0;  // arithmetic and unused codes
    endcase
  end
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] res,
  input  logic         arith,
  input  logic         v_in,
  input  logic         c_in,
  output cc_t          cc
);
  always_comb begin
    cc.neg  = res[W-1];
    cc.zero = ~|res;
    cc.ovf  = arith & v_in;
    cc.cry  = arith & c_in;
  end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int ALU_W = 4
) (
  input  logic [ALU_W-1:0] rega,
  input  logic [ALU_W-1:0] regb,
  input  logic [OP_W-1:0]  controls,
  output logic [ALU_W-1:0] alu_out,
  output logic [CC_W-1:0]  ccr_out
);
  alu_op_e          op;
  logic             is_arith;
  logic             is_sub;
  logic [ALU_W-1:0] as_sum;
  logic             as_cy;
  logic             as_ovf;
  logic [ALU_W-1:0] lg_res;
  cc_t              cc;

  assign op       = alu_op_e'(controls);
  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || is_sub;

  alu4_addsub #(.W(ALU_W)) u_addsub (
    .a     (rega),
    .b     (regb),
    .sub   (is_sub),
    .sum   (as_sum),
    .cy_bw (as_cy),
    .ovf   (as_ovf)
  );

  alu4_logic #(.W(ALU_W)) u_logic (
    .op  (op),
    .a   (rega),
    .b   (regb),
    .res (lg_res)
  );

  assign alu_out = is_arith ? as_sum : lg_res;

  alu4_flags #(.W(ALU_W)) u_flags (
    .res   (alu_out),
    .arith (is_arith),
    .v_in  (as_ovf),
    .c_in  (as_cy),
    .cc    (cc)
  );

  assign ccr_out = cc;
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] rega,
  input logic [W-1:0] regb,
  input logic [3:0]   controls,
  input logic [W-1:0] alu_out,
  input logic [3:0]   ccr_out
);
  logic [W:0] wide_add;
  logic       known;

  assign wide_add = {1'b0, rega} + {1'b0, regb};
  assign known    = !$isunknown({rega, regb, controls, alu_out, ccr_out});

  always_comb begin
    if (known) begin
      if (controls == 4'd0)
        assert_add_sum_R1: assert (alu_out == rega + regb)
          else $error("R1 sum mismatch");
      if (controls == 4'd1)
        assert_sub_diff_R2: assert (alu_out == rega - regb)
          else $error("R2 difference mismatch");
      assert_sign_flag_R5: assert (ccr_out[3] == alu_out[W-1])
        else $error("R5 N flag");
      assert_zero_flag_R5: assert (ccr_out[2] == (alu_out == '0))
        else $error("R5 Z flag");
      if (controls >= 4'd2 && controls <= 4'd5)
        assert_logic_vc_clear_R6: assert (ccr_out[1:0] == 2'b00)
          else $error("R6 V/C not clear");
      if (controls == 4'd0)
        assert_add_carry_R7: assert (ccr_out[0] == wide_add[W])
          else $error("R7 carry");
      if (controls == 4'd1)
        assert_sub_borrow_R8: assert (ccr_out[0] == (rega < regb))
          else $error("R8 borrow");
      if (controls >= 4'd6)
        assert_unused_zero_R11: assert (alu_out == '0 && ccr_out == 4'b0100)
          else $error("R11 unused select");
    end
  end
endmodule

bind alu4_core alu4_core_chk #(.W(ALU_W)) u_chk (
  .rega     (rega),
  .regb     (regb),
  .controls (controls),
  .alu_out  (alu_out),
  .ccr_out  (ccr_out)
);

// File: tb/sim_alu4_core.sv
`timescale 1ns/1ps
module sim_alu4_core;
  logic       clk = 1'b0;
  logic [3:0] rega = '0;
  logic [3:0] regb = '0;
  logic [3:0] controls = '0;
  logic [3:0] alu_out;
  logic [3:0] ccr_out;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  alu4_core u0 (
    .rega     (rega),
    .regb     (regb),
    .controls (controls),
    .alu_out  (alu_out),
    .ccr_out  (ccr_out)
  );

  // Each entry: {select, A, B, expected result, expected flags NZVC}
  localparam logic [19:0] VEC [15] = '{
    {4'h0, 4'h7, 4'h1, 4'h8, 4'b1010},  // R9 positive overflow
    {4'h0, 4'hF, 4'h1, 4'h0, 4'b0101},  // R7 carry, zero
    {4'h0, 4'h8, 4'h8, 4'h0, 4'b0111},  // R9 negative overflow with carry
    {4'h1, 4'h0, 4'h1, 4'hF, 4'b1001},  // R8 borrow
    {4'h1, 4'h8, 4'h1, 4'h7, 4'b0010},  // R10 overflow, no borrow
    {4'h1, 4'h7, 4'hF, 4'h8, 4'b1011},  // R10 overflow with borrow
    {4'h1, 4'h5, 4'h5, 4'h0, 4'b0100},  // R2 equal operands
    {4'h2, 4'hF, 4'h0, 4'h0, 4'b0100},  // R3 AND
    {4'h3, 4'h8, 4'h1, 4'h9, 4'b1000},  // R3 OR, R6
    {4'h4, 4'h0, 4'h3, 4'hF, 4'b1000},  // R4 complement
    {4'h4, 4'hF, 4'h0, 4'h0, 4'b0100},  // R4 complement to zero
    {4'h5, 4'h8, 4'h7, 4'h8, 4'b1000},  // R4 pass
    {4'h5, 4'h0, 4'hF, 4'h0, 4'b0100},  // R4 pass zero
    {4'h6, 4'hF, 4'hF, 4'h0, 4'b0100},  // R11
    {4'hF, 4'h7, 4'h9, 4'h0, 4'b0100}   // R11
  };

  task automatic chk(input string tag, input int got, input int exp, input string what);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s sel=%0d A=%0d B=%0d: got %0d expected %0d",
               tag, what, controls, rega, regb, got, exp);
    end
  endtask

  task automatic drive(input int op, input int a, input int b);
    @(negedge clk);
    controls = 4'(op);
    rega     = 4'(a);
    regb     = 4'(b);
    #1;
  endtask

  // Integer reference model built from the requirements.
  task automatic ref_model(input int op, input int a, input int b,
                           output int r, output int v, output int c);
    int sa, sb, s;
    sa = (a >= 8) ? a - 16 : a;
    sb = (b >= 8) ? b - 16 : b;
    v = 0; c = 0;
    case (op)
      0: begin r = (a + b) % 16; c = (a + b > 15); s = sa + sb; v = (s > 7 || s < -8); end
      1: begin r = (a - b + 16) % 16; c = (a < b); s = sa - sb; v = (s > 7 || s < -8); end
      2: r = a & b;
      3: r = a | b;
      4: r = 15 - a;
      5: r = a;
      default: r = 0;
    endcase
  endtask

  function automatic string res_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      default: return "R11";
    endcase
  endfunction

  function automatic string v_tag(input int op);
    if (op == 0) return "R9";
    if (op == 1) return "R10";
    if (op <= 5) return "R6";
    return "R11";
  endfunction

  function automatic string c_tag(input int op);
    if (op == 0) return "R7";
    if (op == 1) return "R8";
    if (op <= 5) return "R6";
    return "R11";
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // Idle state: ADD of zero operands.
    drive(0, 0, 0);
    chk("R1", int'(alu_out), 0, "idle result");
    chk("R5", int'(ccr_out), 4'b0100, "idle flags");

    // Directed corner vectors.
    for (int i = 0; i < 15; i++) begin
      drive(int'(VEC[i][19:16]), int'(VEC[i][15:12]), int'(VEC[i][11:8]));
      chk(res_tag(int'(VEC[i][19:16])), int'(alu_out), int'(VEC[i][7:4]), "vector result");
      chk(c_tag(int'(VEC[i][19:16])), int'(ccr_out), int'(VEC[i][3:0]), "vector flags");
    end

    // R12: change inputs between edges; outputs follow with no edge.
    @(posedge clk);
    #0.5;
    controls = 4'd0; rega = 4'd3; regb = 4'd4;
    #0.5;
    chk("R12", int'(alu_out), 7, "mid-cycle add");
    controls = 4'd1;
    #0.5;
    chk("R12", int'(alu_out), 15, "mid-cycle sub");
    chk("R12", int'(ccr_out), 4'b1001, "mid-cycle flags");

    // Exhaustive sweep over every select and operand pair.
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int er, ev, ec;
          ref_model(op, a, b, er, ev, ec);
          drive(op, a, b);
          chk(res_tag(op), int'(alu_out), er, "sweep result");
          chk("R5", int'(ccr_out[3]), (er >= 8) ? 1 : 0, "N flag");
          chk("R5", int'(ccr_out[2]), (er == 0) ? 1 : 0, "Z flag");
          chk(v_tag(op), int'(ccr_out[1]), ev, "V flag");
          chk(c_tag(op), int'(ccr_out[0]), ec, "C flag");
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule